// File: doc/BRIEF.md
# Power Supply Supervisor Sequencer

This block supervises the secondary side of a multi-rail power supply and runs its start-up and shutdown sequencing. It takes comparator decisions that are already digital: an overvoltage and an undervoltage flag for each positive and each negative rail. It also takes an input-line-good flag, a bias-valid flag, a remote off request and a switch that takes the negative rails out of monitoring. From these it drives three outputs: a power-good indication, a latched shutdown request and a crowbar drive.

Overvoltage is treated as a hazard. Once filtered, it latches shutdown and crowbar on the next clock. Undervoltage always removes power-good. It can also latch shutdown, but only after a start-up blanking window, and only when enabled. A remote off request withdraws power-good at once and asserts shutdown later. Three counters replace the timing capacitors: blanking, power-good delay and off delay. A small per-flag filter rejects short comparator glitches.

Top module: `psu_supervisor`

## Requirements
- R1: A filtered overvoltage on any monitored rail sets `shutdown` and `crowbar` high at the next clock edge. Both stay high after the flag clears, until a clear event.
- R2: After reset, `pwr_good`, `shutdown` and `crowbar` are low. `crowbar` rises only because of an overvoltage, never because of an undervoltage or the off delay.
- R3: A filtered undervoltage latches `shutdown` only after the blanking counter has counted `BLANK_CYC` cycles. With `uv_fault_en` low, undervoltage never latches `shutdown`.
- R4: The blanking counter is held at zero while `line_ok` is low or `shutdown` is high, so the blanking window restarts when the line returns.
- R5: `pwr_good` falls in the same cycle that a filtered undervoltage appears or `line_ok` goes low. It rises only after `PG_CYC` consecutive clock edges with all conditions good.
- R6: Overvoltage has no effect on `pwr_good`, and the blanking window does not hide undervoltage from `pwr_good`.
- R7: A high-to-low transition of `off_req` clears the shutdown and crowbar latches at the next edge. It also restarts the blanking and power-good counters from zero, so after such a transition `pwr_good` returns `PG_CYC+1` edges later.
- R8: Raising `off_req` drops `pwr_good` in the same cycle. `shutdown` rises `OFF_CYC` edges later. The off-delay counter is held at zero while `off_req` is low.
- R9: While `bias_ok` is low, `pwr_good` is low and no overvoltage or undervoltage can latch `shutdown` or `crowbar`.
- R10: A rail flag is acted on only after it has held a new value for `DG_CYC` consecutive edges. A pulse shorter than that has no effect.
- R11: While `neg_dis` is high, the negative-rail flags affect no output, and the positive rails keep working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ov_pos | input | NPOS | Overvoltage flags, positive rails |
| uv_pos | input | NPOS | Undervoltage flags, positive rails |
| ov_neg | input | NNEG | Overvoltage flags, negative rails |
| uv_neg | input | NNEG | Undervoltage flags, negative rails |
| line_ok | input | 1 | Input line voltage sufficient |
| bias_ok | input | 1 | Reference and bias valid |
| off_req | input | 1 | Remote off request, high requests shutdown |
| neg_dis | input | 1 | Ignore negative-rail flags |
| uv_fault_en | input | 1 | Allow undervoltage into the shutdown latch |
| pwr_good | output | 1 | Power-good indication |
| shutdown | output | 1 | Latched fault / delayed off shutdown |
| crowbar | output | 1 | Crowbar drive, overvoltage only |

## Verification
The hardest state to reach is an undervoltage that arrives inside the blanking window right after a restart. The window only reopens after an off-request falling edge or a dip of `line_ok`, and the deglitch filter must settle before the flag is seen. The stimulus first latches a fault, clears it with an off pulse, and then injects an undervoltage a few cycles later. The undervoltage is held long enough to pass the filter but is released before the window closes. The run checks that `shutdown` stays low while `pwr_good` still drops. A second run does the same after a line dip, and random short glitches on random rails test the filter.

// File: rtl/psu_supervisor.sv
module psu_supervisor #(
  parameter int NPOS      = 3,
  parameter int NNEG      = 2,
  parameter int CLK_HZ    = 200_000_000,
  parameter int DG_CYC    = CLK_HZ / 50_000,
  parameter int BLANK_CYC = CLK_HZ / 20,
  parameter int PG_CYC    = CLK_HZ / 4,
  parameter int OFF_CYC   = CLK_HZ / 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPOS-1:0] ov_pos,
  input  logic [NPOS-1:0] uv_pos,
  input  logic [NNEG-1:0] ov_neg,
  input  logic [NNEG-1:0] uv_neg,
  input  logic            line_ok,
  input  logic            bias_ok,
  input  logic            off_req,
  input  logic            neg_dis,
  input  logic            uv_fault_en,
  output logic            pwr_good,
  output logic            shutdown,
  output logic            crowbar
);
  localparam int NF  = 2 * (NPOS + NNEG);
  localparam int DGW = $clog2(DG_CYC + 1);
  localparam int BW  = $clog2(BLANK_CYC + 1);
  localparam int PW  = $clog2(PG_CYC + 1);
  localparam int OW  = $clog2(OFF_CYC + 1);

  logic [NF-1:0] raw, filt;
  assign raw = {uv_neg, ov_neg, uv_pos, ov_pos};

  for (genvar g = 0; g < NF; g++) begin : g_dg
    logic [DGW-1:0] cnt;
    logic           q;
    always_ff @(posedge clk) begin
      if (!rst_n || !bias_ok) begin
        cnt <= '0;
        q   <= 1'b0;
      end else if (raw[g] == q) begin
        cnt <= '0;
      end else if (cnt == DGW'(DG_CYC - 1)) begin
        q   <= raw[g];
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
    assign filt[g] = q;
  end

  logic ov_any, uv_any;
  assign ov_any = (|filt[NPOS-1:0]) |
                  (!neg_dis & (|filt[2*NPOS+NNEG-1:2*NPOS]));
  assign uv_any = (|filt[2*NPOS-1:NPOS]) |
                  (!neg_dis & (|filt[NF-1:2*NPOS+NNEG]));

  logic off_q, off_fall;
  always_ff @(posedge clk) off_q <= rst_n ? off_req : 1'b0;
  assign off_fall = off_q & ~off_req;

  logic [BW-1:0] bcnt;
  logic [PW-1:0] pcnt;
  logic [OW-1:0] ocnt;
  logic uv_armed, pg_done, off_done, pg_cond, fault_set, fault_q, cb_q;

  assign uv_armed = (bcnt == BW'(BLANK_CYC));
  assign pg_done  = (pcnt == PW'(PG_CYC));
  assign off_done = (ocnt == OW'(OFF_CYC));
  assign shutdown = fault_q | off_done;
  assign crowbar  = cb_q;
  assign pg_cond  = bias_ok & line_ok & ~uv_any & ~off_req;
  assign pwr_good = pg_cond & pg_done;
  assign fault_set = bias_ok & (ov_any | (uv_fault_en & uv_armed & uv_any));

  always_ff @(posedge clk) begin
    if (!rst_n || !bias_ok || !line_ok || shutdown || off_fall) bcnt <= '0;
    else if (!uv_armed)                                           bcnt <= bcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !pg_cond || off_fall) pcnt <= '0;
    else if (!pg_done)                  pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !bias_ok || !off_req) ocnt <= '0;
    else if (!off_done)                 ocnt <= ocnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault_q <= 1'b0;
      cb_q    <= 1'b0;
    end else begin
      if (fault_set)          fault_q <= 1'b1;
      else if (off_fall)      fault_q <= 1'b0;
      if (bias_ok && ov_any)  cb_q    <= 1'b1;
      else if (off_fall)      cb_q    <= 1'b0;
    end
  end

  p_ov_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bias_ok && ov_any) |=> (shutdown && crowbar));
  p_cb_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crowbar) |-> $past(ov_any && bias_ok));
  p_cb_with_sd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    crowbar |-> shutdown);
  p_uv_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_q) |-> $past(ov_any || (uv_armed && uv_fault_en)));
  p_blank_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_ok || shutdown) |=> !uv_armed);
  p_pg_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_any || !line_ok) |-> !pwr_good);
  p_pg_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |-> !pwr_good);
  p_bias_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bias_ok |=> !$rose(shutdown));
endmodule

// File: tb/psu_supervisor_tb.sv
module psu_supervisor_tb;
  localparam int NPOS = 3, NNEG = 2;
  localparam int DG = 4, BL = 40, PG = 60, OFF = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NPOS-1:0] ov_pos = '0, uv_pos = '0;
  logic [NNEG-1:0] ov_neg = '0, uv_neg = '0;
  logic line_ok = 1'b0, bias_ok = 1'b0, off_req = 1'b0, neg_dis = 1'b0, uv_fault_en = 1'b1;
  logic pwr_good, shutdown, crowbar;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  psu_supervisor #(.NPOS(NPOS), .NNEG(NNEG), .DG_CYC(DG), .BLANK_CYC(BL),
                   .PG_CYC(PG), .OFF_CYC(OFF)) u_dut (
    .clk(clk), .rst_n(rst_n), .ov_pos(ov_pos), .uv_pos(uv_pos),
    .ov_neg(ov_neg), .uv_neg(uv_neg), .line_ok(line_ok), .bias_ok(bias_ok),
    .off_req(off_req), .neg_dis(neg_dis), .uv_fault_en(uv_fault_en),
    .pwr_good(pwr_good), .shutdown(shutdown), .crowbar(crowbar));

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic set_flag(input bit is_uv, input int r, input logic v);
    if (r < NPOS) begin
      if (is_uv) uv_pos[r] = v; else ov_pos[r] = v;
    end else begin
      if (is_uv) uv_neg[r-NPOS] = v; else ov_neg[r-NPOS] = v;
    end
  endtask

  task automatic off_pulse();
    off_req = 1'b1; waitn(1);
    off_req = 1'b0; waitn(1);
  endtask

  function automatic logic exp_pg_window(input int edges, input int need);
    return (edges >= need);
  endfunction

  initial begin
    void'($urandom(32'd5150));
    waitn(3);
    chk(pwr_good, 1'b0, "R2 reset pwr_good");
    chk(shutdown, 1'b0, "R2 reset shutdown");
    chk(crowbar,  1'b0, "R2 reset crowbar");
    rst_n = 1'b1;
    bias_ok = 1'b1; line_ok = 1'b1;
    waitn(PG - 1);
    chk(pwr_good, exp_pg_window(PG - 1, PG), "R5 pwr_good before delay");
    waitn(1);
    chk(pwr_good, exp_pg_window(PG, PG), "R5 pwr_good after delay");

    for (int i = 0; i < 12; i++) begin
      automatic int r = int'($urandom_range(NPOS + NNEG - 1, 0));
      automatic bit u = bit'($urandom_range(1, 0));
      automatic int len = int'($urandom_range(DG - 1, 1));
      set_flag(u, r, 1'b1);
      waitn(len);
      set_flag(u, r, 1'b0);
      waitn(DG + 2);
      chk(shutdown, 1'b0, "R10 glitch no shutdown");
      chk(pwr_good, 1'b1, "R10 glitch keeps pwr_good");
    end

    uv_pos[1] = 1'b1;
    waitn(DG - 1);
    chk(pwr_good, 1'b1, "R10 uv not yet filtered");
    waitn(1);
    chk(pwr_good, 1'b0, "R5 uv drops pwr_good");
    waitn(1);
    chk(shutdown, 1'b1, "R3 uv after blanking latches");
    chk(crowbar, 1'b0, "R2 uv no crowbar");
    uv_pos[1] = 1'b0;
    waitn(DG + 1);
    chk(shutdown, 1'b1, "R1 latch holds");
    off_req = 1'b1; waitn(2);
    off_req = 1'b0; waitn(1);
    chk(shutdown, 1'b0, "R7 off fall clears shutdown");
    waitn(PG - 1);
    chk(pwr_good, 1'b0, "R7 pg counter restarted");
    waitn(1);
    chk(pwr_good, 1'b1, "R7 pg after restart");

    off_pulse();
    waitn(4);
    uv_pos[0] = 1'b1;
    waitn(DG + 1);
    chk(pwr_good, 1'b0, "R6 blanking does not mask pg");
    waitn(15);
    uv_pos[0] = 1'b0;
    waitn(20);
    chk(shutdown, 1'b0, "R3 uv inside blanking ignored");
    waitn(PG + 2);
    chk(pwr_good, 1'b1, "R5 pg recovered");

    uv_fault_en = 1'b0;
    uv_pos[2] = 1'b1;
    waitn(DG + 10);
    chk(shutdown, 1'b0, "R3 uv_fault_en low blocks uv");
    chk(pwr_good, 1'b0, "R6 uv still drops pg");
    uv_pos[2] = 1'b0;
    uv_fault_en = 1'b1;
    waitn(DG + PG + 2);
    chk(pwr_good, 1'b1, "R5 pg recovered after uv");

    ov_pos[2] = 1'b1;
    waitn(DG);
    chk(pwr_good, 1'b1, "R6 ov ignored by pg");
    waitn(1);
    chk(shutdown, 1'b1, "R1 ov latches shutdown");
    chk(crowbar, 1'b1, "R1 ov latches crowbar");
    chk(pwr_good, 1'b1, "R6 pg unaffected by ov latch");
    ov_pos[2] = 1'b0;
    waitn(DG + 3);
    chk(crowbar, 1'b1, "R1 crowbar holds");
    off_req = 1'b1; waitn(2);
    off_req = 1'b0; waitn(1);
    chk(shutdown, 1'b0, "R7 clear shutdown");
    chk(crowbar, 1'b0, "R7 clear crowbar");
    waitn(PG + 2);

    line_ok = 1'b0; #1;
    chk(pwr_good, 1'b0, "R5 line low drops pg");
    waitn(2);
    line_ok = 1'b1;
    uv_pos[0] = 1'b1;
    waitn(DG + 5);
    chk(shutdown, 1'b0, "R4 blanking restarted by line dip");
    uv_pos[0] = 1'b0;
    waitn(DG + PG + 2);
    chk(pwr_good, 1'b1, "R5 pg after line dip");

    off_req = 1'b1; #1;
    chk(pwr_good, 1'b0, "R8 off drops pg at once");
    waitn(OFF - 1);
    chk(shutdown, 1'b0, "R8 off delay not expired");
    waitn(1);
    chk(shutdown, 1'b1, "R8 off delay expired");
    chk(crowbar, 1'b0, "R2 off path no crowbar");
    off_req = 1'b0; waitn(1);
    chk(shutdown, 1'b0, "R8 off low releases");
    waitn(PG + 2);

    neg_dis = 1'b1;
    ov_neg[0] = 1'b1;
    waitn(DG + 3);
    chk(shutdown, 1'b0, "R11 neg ov ignored");
    uv_neg[1] = 1'b1;
    waitn(DG + 2);
    chk(pwr_good, 1'b1, "R11 neg uv ignored");
    uv_neg[1] = 1'b0;
    waitn(DG + 2);
    neg_dis = 1'b0;
    waitn(1);
    chk(shutdown, 1'b1, "R11 neg ov after enable");
    chk(crowbar, 1'b1, "R11 neg ov crowbar");
    ov_neg[0] = 1'b0;
    waitn(DG + 2);
    off_pulse();
    waitn(PG + 2);
    chk(pwr_good, 1'b1, "R11 pg restored");

    bias_ok = 1'b0; #1;
    chk(pwr_good, 1'b0, "R9 bias low drops pg");
    ov_pos[0] = 1'b1;
    waitn(DG + 3);
    chk(shutdown, 1'b0, "R9 no shutdown without bias");
    chk(crowbar, 1'b0, "R9 no crowbar without bias");
    ov_pos[0] = 1'b0;
    waitn(2);
    bias_ok = 1'b1;
    waitn(PG - 1);
    chk(pwr_good, 1'b0, "R9 pg delay after bias");
    waitn(1);
    chk(pwr_good, 1'b1, "R9 pg after bias");

    for (int i = 0; i < 4; i++) begin
      automatic int r = int'($urandom_range(NPOS + NNEG - 1, 0));
      set_flag(1'b0, r, 1'b1);
      waitn(DG + 1);
      chk(shutdown, 1'b1, "R1 random rail ov shutdown");
      chk(crowbar, 1'b1, "R1 random rail ov crowbar");
      set_flag(1'b0, r, 1'b0);
      waitn(DG + 1);
      off_pulse();
      chk(crowbar, 1'b0, "R7 random clear");
      waitn(PG + 2);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule